// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Position Counter

This block turns the two phase signals of an incremental encoder into a binary position. Both channels are first brought into the system clock domain and then cleaned: a level reaches the decoder only once it has been steady for a set number of clock samples. Short noise spikes therefore never reach the decoder. The decoder compares each accepted channel pair with the pair before it. Each legal single-channel change gives one step, so one full encoder cycle gives four steps.

Every step is shown on the outputs as a one-cycle strobe with a direction bit. The same step moves an up/down counter. Its width is a parameter, set to 12 or 16 bits. If both channels change in the same sample, the pair is illegal: the count is left alone and a one-cycle error flag is raised instead. When the counter passes its terminal value in either direction, the block gives a one-cycle wrap strobe with its own direction bit. An outside counter can use these to extend the range.

Top module: `quad_pos_counter`

## Requirements
- R1: Each channel passes through a two-flop synchronizer and then a stability filter. A channel level is accepted only after FILT_LEN (default 3) consecutive equal synchronized samples. A pulse lasting fewer samples produces no strobe and leaves the count unchanged. A pulse lasting exactly FILT_LEN samples is accepted.
- R2: Every accepted single-channel change produces exactly one step, which gives four steps per full quadrature cycle.
- R3: The state is written as the pair (A,B). The sequence 00→10→11→01→00 (A leads B) counts up and the reverse sequence counts down. step_up is 1 for an up step and 0 for a down step.
- R4: step_stb, step_err and wrap_stb each last exactly one clock cycle per event. step_stb and step_err are never high together.
- R5: When both accepted channels change in the same cycle, step_err pulses, no step_stb is produced, and the count keeps its value.
- R6: An up step taken when the count is all ones makes the count zero. In the same cycle that the new count appears, wrap_stb pulses with wrap_up = 1.
- R7: A down step taken when the count is zero makes the count all ones. In the same cycle that the new count appears, wrap_stb pulses with wrap_up = 0.
- R8: The parameter CNT_W sets the counter width and must be 12 or 16. The count port is CNT_W bits wide.
- R9: While reset is active and after it is released, the count is zero, all strobes are low, and both accepted channel levels are 0.
- R10: The count shows the result of a step on the clock cycle after its step_stb. The count stays unchanged in every cycle that follows no step_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| count | output | CNT_W | Position counter |
| step_stb | output | 1 | One-cycle pulse for each decoded step |
| step_up | output | 1 | Direction of the step, valid with step_stb (1 = up) |
| step_err | output | 1 | One-cycle pulse for an illegal two-channel change |
| wrap_stb | output | 1 | One-cycle pulse when the counter passes its terminal value |
| wrap_up | output | 1 | Direction of the wrap, valid with wrap_stb (1 = up) |

## Verification
The bench builds the block with CNT_W = 12 and FILT_LEN = 3. With a 12-bit counter, one down step from reset reaches the all-ones terminal value, so both wrap directions are tested within a few steps. With a filter length of 3, a two-sample pulse tests the rejection side of the filter and a three-sample pulse tests the acceptance side, both in a short run. A 16-bit build runs the same logic with a wider mask, and the width check accepts that value as well.

// File: rtl/quad_pkg.sv
package quad_pkg;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DN   = 2'd2,
    MOVE_BAD  = 2'd3
  } move_e;

  // Classify the change from the old (a,b) pair to the new one.
  function automatic move_e classify(input logic old_a, input logic old_b,
                                     input logic new_a, input logic new_b);
    logic a_chg;
    logic b_chg;
    a_chg = old_a ^ new_a;
    b_chg = old_b ^ new_b;
    if (a_chg && b_chg)   return MOVE_BAD;
    else if (a_chg)       return (new_a != old_b) ? MOVE_UP : MOVE_DN;
    else if (b_chg)       return (new_b == old_a) ? MOVE_UP : MOVE_DN;
    else                  return MOVE_NONE;
  endfunction

endpackage

// File: rtl/quad_glitch_filter.sv
module quad_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic din,
  output logic level
);

  localparam int RUN_W = $clog2(FILT_LEN + 1);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                level_q;
  logic                level_d;

  always_comb begin
    level_d = level_q;
    if (&hist_q)       level_d = 1'b1;
    else if (~|hist_q) level_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      hist_q  <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], din};
      hist_q  <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      level_q <= level_d;
    end
  end

  assign level = level_q;

  // Checker: cycles since the last change of the accepted level.
  logic [RUN_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                         since_q <= '0;
    else if (level_d != level_q)         since_q <= '0;
    else if (since_q != RUN_W'(FILT_LEN)) since_q <= since_q + 1'b1;
  end

  AST_FILT_SPACING: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(level_q) |-> (int'($past(since_q)) >= FILT_LEN - 1)); // R1

endmodule

// File: rtl/quad_step_decoder.sv
module quad_step_decoder
  import quad_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic lvl_a,
  input  logic lvl_b,
  output logic step_stb,
  output logic step_up,
  output logic step_err
);

  logic  prev_a_q, prev_b_q;
  logic  stb_q, up_q, err_q;
  logic  stb_d, up_d, err_d;
  move_e move;

  always_comb begin
    move  = classify(prev_a_q, prev_b_q, lvl_a, lvl_b);
    stb_d = (move == MOVE_UP) || (move == MOVE_DN);
    up_d  = (move == MOVE_UP) ? 1'b1 : ((move == MOVE_DN) ? 1'b0 : up_q);
    err_d = (move == MOVE_BAD);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
      stb_q    <= 1'b0;
      up_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      prev_a_q <= lvl_a;
      prev_b_q <= lvl_b;
      stb_q    <= stb_d;
      up_q     <= up_d;
      err_q    <= err_d;
    end
  end

  assign step_stb = stb_q;
  assign step_up  = up_q;
  assign step_err = err_q;

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    step_stb |=> !step_stb); // R4
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    step_err |=> !step_err); // R4
  AST_STB_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(step_stb && step_err)); // R5

endmodule

// File: rtl/quad_pos_accum.sv
module quad_pos_accum #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             stb,
  input  logic             up,
  output logic [CNT_W-1:0] count,
  output logic             wrap_stb,
  output logic             wrap_up
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;
  logic             wup_q, wup_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    wup_d  = wup_q;
    if (stb) begin
      if (up) begin
        cnt_d  = cnt_q + 1'b1;
        wrap_d = (cnt_q == CNT_MAX);
      end else begin
        cnt_d  = cnt_q - 1'b1;
        wrap_d = (cnt_q == '0);
      end
      if (wrap_d) wup_d = up;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      wup_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
      wup_q  <= wup_d;
    end
  end

  assign count    = cnt_q;
  assign wrap_stb = wrap_q;
  assign wrap_up  = wup_q;

  AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_ni)
    (stb && up) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
  AST_CNT_DN: assert property (@(posedge clk) disable iff (!rst_ni)
    (stb && !up) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !stb |=> $stable(cnt_q)); // R10
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_ni)
    (wrap_stb && wrap_up) |-> (cnt_q == '0)); // R6
  AST_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_ni)
    (wrap_stb && !wrap_up) |-> (cnt_q == CNT_MAX)); // R7
  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    wrap_stb |=> !wrap_stb); // R4

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CNT_W    = 12,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic [CNT_W-1:0] count,
  output logic             step_stb,
  output logic             step_up,
  output logic             step_err,
  output logic             wrap_stb,
  output logic             wrap_up
);

  localparam int NCH = 2;

  initial begin
    AST_WIDTH_SEL: assert (CNT_W == 12 || CNT_W == 16); // R8
  end

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NCH-1:0] enc_raw;
  logic [NCH-1:0] enc_lvl;
  assign enc_raw = {enc_b, enc_a};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    quad_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_ni (rst_sync_q),
      .din    (enc_raw[ch]),
      .level  (enc_lvl[ch])
    );
  end

  quad_step_decoder u_dec (
    .clk      (clk),
    .rst_ni   (rst_sync_q),
    .lvl_a    (enc_lvl[0]),
    .lvl_b    (enc_lvl[1]),
    .step_stb (step_stb),
    .step_up  (step_up),
    .step_err (step_err)
  );

  quad_pos_accum #(.CNT_W(CNT_W)) u_acc (
    .clk      (clk),
    .rst_ni   (rst_sync_q),
    .stb      (step_stb),
    .up       (step_up),
    .count    (count),
    .wrap_stb (wrap_stb),
    .wrap_up  (wrap_up)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |-> (!step_stb && !step_err && !wrap_stb && count == '0)); // R9

endmodule

// File: tb/sim_quad_pos_counter.sv
module sim_quad_pos_counter;

  localparam int CNT_W = 12;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam int K_UP  = 0;
  localparam int K_DN  = 1;
  localparam int K_ERR = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enc_a = 1'b0;
  logic             enc_b = 1'b0;
  logic [CNT_W-1:0] count;
  logic             step_stb, step_up, step_err, wrap_stb, wrap_up;

  always #5 clk = ~clk;

  quad_pos_counter #(.CNT_W(CNT_W), .FILT_LEN(3)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .count(count), .step_stb(step_stb), .step_up(step_up),
    .step_err(step_err), .wrap_stb(wrap_stb), .wrap_up(wrap_up)
  );

  int checks = 0;
  int errors = 0;
  int q_kind[$];
  int q_cnt[$];
  int q_wrap[$];   // 0 none, 1 wrap up, 2 wrap down
  int model_cnt = 0;
  bit mon_on = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  // Driver: move encoder to (a,b), push expected item, let pipeline settle.
  task automatic push_move(input logic na, input logic nb);
    int kind, wr;
    logic ca, cb;
    ca = enc_a; cb = enc_b;
    wr = 0;
    if ((ca != na) && (cb != nb)) kind = K_ERR;
    else if (ca != na) kind = (na != cb) ? K_UP : K_DN;
    else kind = (nb == ca) ? K_UP : K_DN;
    if (kind == K_UP) begin
      if (model_cnt == MAXV) begin model_cnt = 0; wr = 1; end
      else model_cnt = model_cnt + 1;
    end else if (kind == K_DN) begin
      if (model_cnt == 0) begin model_cnt = MAXV; wr = 2; end
      else model_cnt = model_cnt - 1;
    end
    q_kind.push_back(kind);
    q_cnt.push_back(model_cnt);
    q_wrap.push_back(wr);
  endtask

  task automatic step_to(input logic na, input logic nb);
    @(negedge clk);
    push_move(na, nb);
    enc_a = na; enc_b = nb;
    repeat (12) @(negedge clk);
  endtask

  // Monitor: pop expected item on each strobe, check count next cycle.
  bit pend = 0;
  int pend_cnt, pend_wrap, pend_kind;
  bit prev_stb = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (step_stb && prev_stb) check("R4", 1, 0, "step_stb longer than one cycle");
      if (pend) begin
        check("R10", int'(count), pend_cnt, "count after step");
        check(pend_wrap == 2 ? "R7" : "R6", int'(wrap_stb), pend_wrap != 0 ? 1 : 0, "wrap_stb");
        if (pend_wrap != 0) check(pend_wrap == 2 ? "R7" : "R6", int'(wrap_up), pend_wrap == 1 ? 1 : 0, "wrap_up");
        pend = 0;
      end else if (wrap_stb) begin
        check("R4", 1, 0, "wrap_stb without step");
      end
      if (step_stb || step_err) begin
        if (q_kind.size() == 0) begin
          check("R1", 1, 0, "unexpected strobe");
        end else begin
          pend_kind = q_kind.pop_front();
          pend_cnt  = q_cnt.pop_front();
          pend_wrap = q_wrap.pop_front();
          pend = 1;
          check("R5", int'(step_stb && step_err), 0, "stb and err together");
          if (pend_kind == K_ERR) begin
            check("R5", int'(step_err), 1, "step_err on illegal change");
          end else begin
            check("R2", int'(step_stb), 1, "step_stb on legal change");
            check("R3", int'(step_up), pend_kind == K_UP ? 1 : 0, "step_up direction");
          end
        end
      end
      prev_stb = step_stb;
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R9", int'(count), 0, "count in reset");
    check("R9", int'(step_stb | step_err | wrap_stb), 0, "strobes in reset");
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R9", int'(count), 0, "count after reset");
    check("R9", int'(step_stb | step_err | wrap_stb), 0, "strobes after reset");
    mon_on = 1;

    // R2 R3: full cycle up, then back down
    step_to(1, 0); step_to(1, 1); step_to(0, 1); step_to(0, 0);
    check("R2", int'(count), 4, "count after one full up cycle");
    step_to(0, 1); step_to(1, 1); step_to(1, 0); step_to(0, 0);
    check("R3", int'(count), 0, "count after full down cycle");

    // R7 then R6: wrap down from zero, wrap up from all ones
    step_to(0, 1);
    check("R7", int'(count), MAXV, "count after down wrap");
    step_to(0, 0);
    check("R6", int'(count), 0, "count after up wrap");

    // R5: illegal double change
    step_to(1, 1);
    check("R5", int'(count), 0, "count held on illegal change");
    step_to(1, 0);   // down from 11 -> wraps
    step_to(0, 0);   // down
    check("R3", int'(count), MAXV - 1, "count after two downs");

    // R1: two-sample glitch on A is rejected
    @(negedge clk); enc_a = 1'b1;
    repeat (2) @(negedge clk); enc_a = 1'b0;
    repeat (14) @(negedge clk);
    check("R1", int'(count), MAXV - 1, "count after short glitch");

    // R1: three-sample pulse on A is accepted (up then down)
    @(negedge clk);
    push_move(1, 0); enc_a = 1'b1;
    repeat (3) @(negedge clk);
    push_move(0, 0); enc_a = 1'b0;
    repeat (14) @(negedge clk);
    check("R1", int'(count), MAXV - 1, "count after accepted pulse pair");
    check("R1", q_kind.size(), 0, "accepted pulse produced both steps");

    repeat (5) @(negedge clk);
    check("R10", int'(count), model_cnt, "final count");
    check("R2", q_kind.size(), 0, "all expected steps seen");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule